// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs complete I2C master write and read transactions in hardware. It sits above a byte engine that performs the bus-level work: conditions, shifting and acknowledge sampling. After every step the engine reports a status code. The sequencer answers each code with the next engine action: a START, a byte to send, a receive with ACK, a receive with NACK, or a STOP. No processor has to service each step.

A command gives a 7-bit slave address, a direction, a byte count and a chaining flag. Write data is taken from a small transmit buffer. Received bytes are stored in order in a receive buffer, and the user reads them back by index. A result code reports the outcome, and a mode output shows the phase of the transaction.

When the chaining flag is set, the sequencer ends the transaction with a repeated START instead of a STOP and keeps the bus. The next command then goes straight to its address byte without a START of its own.

Top module: `i2c_txn_seq`

## Requirements
- R1: `mode` uses the codes Ready=0, Initializing=1, RepeatedStartSent=2, MasterTransmitter=3 and MasterReceiver=4, and resets to Ready. A command is accepted only in Ready or RepeatedStartSent, and acceptance moves the mode to Initializing. Status 0x18 sets MasterTransmitter and status 0x40 sets MasterReceiver. `busy` is high in every other mode.
- R2: `result` resets to 0xFF. It becomes 0xF8 when a command is accepted and stays 0xF8 while bytes are still being moved. It becomes 0xFF when a transaction completes without error.
- R3: Engine actions are pulsed on `eng_go` with `eng_op` coded START=1, SEND=2, RECV_ACK=3, RECV_NACK=4 and STOP=5. A command accepted in Ready issues START. On status 0x08, 0x18 or 0x28 the sequencer sends the next pending byte: the address byte first, then transmit buffer entries 0 upward. When no byte remains, it issues STOP and returns to Ready.
- R4: With chaining set, the end of a transaction issues START instead of STOP and leaves the mode unchanged. Status 0x10 then moves to RepeatedStartSent without any engine action. A command accepted there issues SEND of its address byte directly.
- R5: On a read, status 0x40 issues RECV_ACK if more than one byte is wanted, and RECV_NACK for a single-byte read. Each later receive is ACKed except the one for the last byte, which is NACKed.
- R6: On status 0x50 or 0x58, `eng_rdata` is stored in the receive buffer at the next index, starting from 0 for each command. Status 0x58 completes the transaction.
- R7: On status 0x20, 0x30, 0x38 or 0x48, `result` takes the status value. The sequencer then issues STOP and returns to Ready, or issues START if chaining was requested.
- R8: The address byte is the 7-bit address in bits 7:1, with bit 0 set to 1 for a read and 0 for a write.
- R9: A write count above DEPTH (14) is rejected. A read count is accepted only from 1 to DEPTH-1.
- R10: A rejected command, whether it is rejected for its count or for arriving while busy, pulses `cmd_reject` for one cycle. It changes neither `mode` nor `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | 7 | Slave address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | LW | Byte count |
| cmd_chain | input | 1 | End with repeated START instead of STOP |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |
| tx_we | input | 1 | Transmit buffer write enable |
| tx_idx | input | IW | Transmit buffer write index |
| tx_data | input | 8 | Transmit buffer write data |
| rx_idx | input | IW | Receive buffer read index |
| rx_data | output | 8 | Receive buffer read data |
| eng_evt | input | 1 | Engine status valid strobe |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_go | output | 1 | Engine action strobe |
| eng_op | output | 3 | Engine action code |
| eng_wdata | output | 8 | Byte for a SEND action |
| busy | output | 1 | Transaction in progress |
| mode | output | 3 | Current mode code |
| result | output | 8 | Outcome code |

## Verification
The bench builds the block with DEPTH=14, so LW and IW are both 4. At this size the full-buffer write count of 14, the first refused write count of 15, and the read limit of 13 accepted against 14 refused can all be driven directly. A behavioural model built on a byte queue and a remaining-count integer follows every command and status code, and it is compared with the outputs each cycle. Directed sequences cover multi-byte and single-byte reads, a chain from a write into a read, and chained and unchained failures.

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int DEPTH = 14,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [6:0]    cmd_addr,
  input  logic          cmd_read,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_chain,
  output logic          cmd_reject,
  input  logic          tx_we,
  input  logic [IW-1:0] tx_idx,
  input  logic [7:0]    tx_data,
  input  logic [IW-1:0] rx_idx,
  output logic [7:0]    rx_data,
  input  logic          eng_evt,
  input  logic [7:0]    eng_status,
  input  logic [7:0]    eng_rdata,
  output logic          eng_go,
  output logic [2:0]    eng_op,
  output logic [7:0]    eng_wdata,
  output logic          busy,
  output logic [2:0]    mode,
  output logic [7:0]    result
);
  typedef enum logic [2:0] {M_READY = 3'd0, M_INIT = 3'd1, M_RSS = 3'd2, M_MT = 3'd3, M_MR = 3'd4} mode_t;
  localparam logic [2:0] OP_START = 3'd1, OP_SEND = 3'd2, OP_ACK = 3'd3, OP_NACK = 3'd4, OP_STOP = 3'd5;

  mode_t         mode_q;
  logic [7:0]    res_q, wd_q;
  logic [2:0]    op_q;
  logic          go_q, rej_q, rd_q, chain_q;
  logic [6:0]    addr_q;
  logic [LW-1:0] len_q, pos_q, rxi_q;
  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];

  logic          idle, len_ok, accept, more, ack_more, rx_we, ev;
  logic [LW:0]   total;
  logic [7:0]    next_byte;

  assign idle      = (mode_q == M_READY) || (mode_q == M_RSS);
  assign busy      = !idle;
  assign len_ok    = cmd_read ? (cmd_len != '0 && cmd_len < LW'(DEPTH)) : (cmd_len <= LW'(DEPTH));
  assign accept    = cmd_valid && idle && len_ok;
  assign ev        = eng_evt && busy;
  assign total     = rd_q ? (LW+1)'(1) : (LW+1)'(len_q) + (LW+1)'(1);
  assign more      = (LW+1)'(pos_q) < total;
  assign next_byte = (pos_q == '0) ? {addr_q, rd_q} : txm[IW'(pos_q - 1'b1)];
  assign ack_more  = ((LW+1)'(rxi_q) + (LW+1)'(2)) < (LW+1)'(len_q);
  assign rx_we     = ev && (eng_status == 8'h50 || eng_status == 8'h58) && rxi_q < LW'(DEPTH);

  assign cmd_reject = rej_q;
  assign eng_go     = go_q;
  assign eng_op     = op_q;
  assign eng_wdata  = wd_q;
  assign mode       = mode_q;
  assign result     = res_q;
  assign rx_data    = rxm[rx_idx];

  always_ff @(posedge clk) begin
    if (tx_we) txm[tx_idx] <= tx_data;
    if (rx_we) rxm[IW'(rxi_q)] <= eng_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_READY; res_q <= 8'hFF; go_q <= 1'b0; rej_q <= 1'b0;
      op_q <= '0; wd_q <= '0; rd_q <= 1'b0; chain_q <= 1'b0;
      addr_q <= '0; len_q <= '0; pos_q <= '0; rxi_q <= '0;
    end else begin
      go_q  <= 1'b0;
      rej_q <= 1'b0;
      if (cmd_valid) begin
        if (accept) begin
          addr_q <= cmd_addr; rd_q <= cmd_read; chain_q <= cmd_chain; len_q <= cmd_len;
          rxi_q <= '0; res_q <= 8'hF8; mode_q <= M_INIT; go_q <= 1'b1;
          if (mode_q == M_RSS) begin
            op_q <= OP_SEND; wd_q <= {cmd_addr, cmd_read}; pos_q <= LW'(1);
          end else begin
            op_q <= OP_START; pos_q <= '0;
          end
        end else begin
          rej_q <= 1'b1;
        end
      end
      if (ev) begin
        case (eng_status)
          8'h08, 8'h18, 8'h28: begin
            if (eng_status == 8'h18) mode_q <= M_MT;
            go_q <= 1'b1;
            if (more) begin
              op_q <= OP_SEND; wd_q <= next_byte; pos_q <= pos_q + 1'b1; res_q <= 8'hF8;
            end else begin
              res_q <= 8'hFF;
              op_q <= chain_q ? OP_START : OP_STOP;
              if (!chain_q) mode_q <= M_READY;
            end
          end
          8'h10: mode_q <= M_RSS;
          8'h40: begin
            mode_q <= M_MR; go_q <= 1'b1;
            op_q <= (len_q > LW'(1)) ? OP_ACK : OP_NACK;
          end
          8'h50: begin
            rxi_q <= rxi_q + 1'b1; go_q <= 1'b1;
            op_q <= ack_more ? OP_ACK : OP_NACK;
          end
          8'h58, 8'h20, 8'h30, 8'h38, 8'h48: begin
            if (eng_status == 8'h58) begin
              rxi_q <= rxi_q + 1'b1; res_q <= 8'hFF;
            end else begin
              res_q <= eng_status;
            end
            go_q <= 1'b1;
            op_q <= chain_q ? OP_START : OP_STOP;
            if (!chain_q) mode_q <= M_READY;
          end
          default: ;
        endcase
      end
    end
  end

  p_busy_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> cmd_reject);
  p_read_done_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev && eng_status == 8'h58 |=> result == 8'hFF);
  p_repstart_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev && eng_status == 8'h10 |=> !eng_go && mode_q == M_RSS);
  p_single_read_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev && eng_status == 8'h40 && len_q == LW'(1) |=> eng_go && eng_op == OP_NACK);
  p_fail_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev && eng_status == 8'h48 && !chain_q |=> eng_go && eng_op == OP_STOP && mode_q == M_READY && result == 8'h48);
  p_direct_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && mode_q == M_RSS && !cmd_read && cmd_len == '0 |=> eng_go && eng_op == OP_SEND && eng_wdata[0] == 1'b0);
  p_zero_read_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && idle && cmd_read && cmd_len == '0 |=> cmd_reject && $stable(mode_q) && $stable(res_q));
endmodule

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb;
  localparam int DEPTH = 14;
  localparam int IW = 4;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_read = 0, cmd_chain = 0, cmd_reject;
  logic [6:0] cmd_addr = 0;
  logic [LW-1:0] cmd_len = 0;
  logic tx_we = 0;
  logic [IW-1:0] tx_idx = 0, rx_idx = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic eng_evt = 0;
  logic [7:0] eng_status = 0, eng_rdata = 0;
  logic eng_go, busy;
  logic [2:0] eng_op, mode;
  logic [7:0] eng_wdata, result;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_txn_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_len(cmd_len), .cmd_chain(cmd_chain), .cmd_reject(cmd_reject), .tx_we(tx_we),
    .tx_idx(tx_idx), .tx_data(tx_data), .rx_idx(rx_idx), .rx_data(rx_data), .eng_evt(eng_evt),
    .eng_status(eng_status), .eng_rdata(eng_rdata), .eng_go(eng_go), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .busy(busy), .mode(mode), .result(result));

  // behavioural reference model
  int m_mode, m_res, m_op, m_wd, m_left;
  bit m_go, m_rej, m_chain;
  byte unsigned txc [DEPTH];
  byte unsigned txq [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_res = 8'hFF; m_go = 0; m_rej = 0; m_op = 0; m_wd = 0; m_left = 0; m_chain = 0;
      txq.delete();
    end else begin
      bit was_idle, fin;
      was_idle = (m_mode == 0 || m_mode == 2);
      fin = 0;
      m_go = 0; m_rej = 0;
      if (cmd_valid) begin
        bit ok;
        ok = cmd_read ? (cmd_len >= 1 && cmd_len <= DEPTH - 1) : (cmd_len <= DEPTH);
        if (was_idle && ok) begin
          txq.delete();
          txq.push_back({cmd_addr, cmd_read});
          if (!cmd_read) for (int i = 0; i < cmd_len; i++) txq.push_back(txc[i]);
          m_left = cmd_len; m_chain = cmd_chain; m_res = 8'hF8; m_go = 1;
          if (m_mode == 2) begin m_op = 2; m_wd = txq.pop_front(); end
          else m_op = 1;
          m_mode = 1;
        end else m_rej = 1;
      end
      if (eng_evt && !was_idle) begin
        case (eng_status)
          8'h08, 8'h18, 8'h28: begin
            if (eng_status == 8'h18) m_mode = 3;
            if (txq.size() > 0) begin m_go = 1; m_op = 2; m_wd = txq.pop_front(); m_res = 8'hF8; end
            else begin m_res = 8'hFF; fin = 1; end
          end
          8'h10: m_mode = 2;
          8'h40: begin m_mode = 4; m_go = 1; m_op = (m_left > 1) ? 3 : 4; end
          8'h50: begin m_left--; m_go = 1; m_op = (m_left > 1) ? 3 : 4; end
          8'h58: begin m_left--; m_res = 8'hFF; fin = 1; end
          8'h20, 8'h30, 8'h38, 8'h48: begin m_res = eng_status; fin = 1; end
          default: ;
        endcase
        if (fin) begin
          m_go = 1;
          if (m_chain) m_op = 1;
          else begin m_op = 5; m_mode = 0; end
        end
      end
      if (tx_we) txc[tx_idx] = tx_data;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 model mode", mode, m_mode);
      chk("R1 model busy", busy, !(m_mode == 0 || m_mode == 2));
      chk("R2 model result", result, m_res);
      chk("R10 model reject", cmd_reject, m_rej);
      chk("R3 model go", eng_go, m_go);
      if (m_go) chk("R3 model op", eng_op, m_op);
      if (m_go && m_op == 2) chk("R8 model wdata", eng_wdata, m_wd);
    end
  end

  task automatic evt(input logic [7:0] st, input logic [7:0] rd);
    @(negedge clk); eng_evt = 1; eng_status = st; eng_rdata = rd;
    @(negedge clk); eng_evt = 0;
  endtask

  task automatic cmd(input logic [6:0] a, input logic r, input int n, input logic ch);
    @(negedge clk); cmd_valid = 1; cmd_addr = a; cmd_read = r; cmd_len = LW'(n); cmd_chain = ch;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic txw(input int i, input logic [7:0] d);
    @(negedge clk); tx_we = 1; tx_idx = IW'(i); tx_data = d;
    @(negedge clk); tx_we = 0;
  endtask

  task automatic rxchk(string tag, input int i, input int exp);
    rx_idx = IW'(i); #1;
    chk(tag, rx_data, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R2 reset result", result, 8'hFF);
    chk("R1 reset busy", busy, 0);

    // two-byte write, STOP at end
    txw(0, 8'h11); txw(1, 8'h22);
    cmd(7'h52, 0, 2, 0);
    chk("R3 start issued", eng_op, 1);
    chk("R2 in progress", result, 8'hF8);
    chk("R1 initializing", mode, 1);
    evt(8'h08, 0);
    chk("R8 write address byte", eng_wdata, 8'hA4);
    evt(8'h18, 0);
    chk("R1 transmitter mode", mode, 3);
    chk("R3 first data", eng_wdata, 8'h11);
    evt(8'h28, 0);
    chk("R3 second data", eng_wdata, 8'h22);
    evt(8'h28, 0);
    chk("R3 stop at end", eng_op, 5);
    chk("R2 success", result, 8'hFF);
    chk("R3 back to ready", mode, 0);

    // three-byte read
    cmd(7'h33, 1, 3, 0);
    evt(8'h08, 0);
    chk("R8 read address byte", eng_wdata, 8'h67);
    evt(8'h40, 0);
    chk("R1 receiver mode", mode, 4);
    chk("R5 ack first", eng_op, 3);
    evt(8'h50, 8'hA1);
    chk("R5 ack middle", eng_op, 3);
    evt(8'h50, 8'hB2);
    chk("R5 nack last", eng_op, 4);
    evt(8'h58, 8'hC3);
    chk("R6 stop after last", eng_op, 5);
    chk("R6 result ok", result, 8'hFF);
    rxchk("R6 rx byte 0", 0, 8'hA1);
    rxchk("R6 rx byte 1", 1, 8'hB2);
    rxchk("R6 rx byte 2", 2, 8'hC3);

    // single-byte read
    cmd(7'h01, 1, 1, 0);
    evt(8'h08, 0);
    evt(8'h40, 0);
    chk("R5 single byte nack", eng_op, 4);
    evt(8'h58, 8'h3C);
    rxchk("R6 single rx byte", 0, 8'h3C);

    // chained write then direct read
    txw(0, 8'h77);
    cmd(7'h20, 0, 1, 1);
    evt(8'h08, 0); evt(8'h18, 0);
    chk("R3 chained data", eng_wdata, 8'h77);
    evt(8'h28, 0);
    chk("R4 repeated start op", eng_op, 1);
    chk("R4 mode kept", mode, 3);
    chk("R2 chained success", result, 8'hFF);
    evt(8'h10, 0);
    chk("R4 no action on 0x10", eng_go, 0);
    chk("R4 rep-start mode", mode, 2);
    cmd(7'h20, 1, 1, 0);
    chk("R4 direct address send", eng_op, 2);
    chk("R8 direct read address", eng_wdata, 8'h41);
    evt(8'h40, 0);
    evt(8'h58, 8'h5A);
    chk("R4 chain ends ready", mode, 0);
    rxchk("R6 chained rx", 0, 8'h5A);

    // failures
    cmd(7'h10, 0, 2, 0);
    evt(8'h08, 0); evt(8'h20, 0);
    chk("R7 addr nack result", result, 8'h20);
    chk("R7 stop on fail", eng_op, 5);
    chk("R7 ready on fail", mode, 0);
    cmd(7'h10, 0, 2, 1);
    evt(8'h08, 0); evt(8'h18, 0); evt(8'h30, 0);
    chk("R7 data nack result", result, 8'h30);
    chk("R7 chained fail start", eng_op, 1);
    evt(8'h10, 0);
    cmd(7'h10, 0, 0, 0);
    chk("R8 zero-length write address", eng_wdata, 8'h20);
    evt(8'h38, 0);
    chk("R7 arbitration result", result, 8'h38);
    chk("R7 arbitration ready", mode, 0);
    cmd(7'h7F, 1, 2, 0);
    evt(8'h08, 0);
    chk("R8 read of 0x7F", eng_wdata, 8'hFF);
    evt(8'h48, 0);
    chk("R7 read nack result", result, 8'h48);

    // length limits and rejects
    cmd(7'h05, 0, 15, 0);
    chk("R9 write 15 refused", cmd_reject, 1);
    chk("R10 mode unchanged", mode, 0);
    chk("R10 result unchanged", result, 8'h48);
    cmd(7'h05, 1, 14, 0);
    chk("R9 read 14 refused", cmd_reject, 1);
    cmd(7'h05, 1, 0, 0);
    chk("R9 read 0 refused", cmd_reject, 1);
    cmd(7'h05, 0, 14, 0);
    chk("R9 write 14 accepted", eng_op, 1);
    chk("R9 write 14 no reject", cmd_reject, 0);
    evt(8'h20, 0);
    cmd(7'h05, 1, 13, 0);
    chk("R9 read 13 accepted", mode, 1);
    cmd(7'h06, 0, 1, 0);
    chk("R10 busy refused", cmd_reject, 1);
    chk("R10 busy mode unchanged", mode, 1);
    chk("R10 busy result unchanged", result, 8'hF8);
    evt(8'h08, 0); evt(8'h48, 0);
    chk("R7 final ready", mode, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule